// File: doc/BRIEF.md
# Dual-Driver GPIO Port with Pullups

This block is a general-purpose I/O port of `PINS` pins (16 by default) behind a small register bus. Each pin has a two-bit field in a control word: one bit lets the CPU drive the pin from its data register, the other enables a pullup. An attached peripheral can drive any pin at the same time through its own direction and data inputs. The block combines the three sources into one resolved level per pin and presents it both on an output and on a read of the data register.

The block watches the resolved levels for change, whether the change comes from a control or data write or from the peripheral inputs. Each of `SLOTS` peripheral slots owns a trigger mask. When a changed pin falls inside a slot's mask, that slot gets a one-cycle notification pulse. A word for I/O-interrupt control can be written and read back, but it does not raise any interrupt and has no effect on the pins.

Top module: `gpio_dual_port`

## Requirements
- R1: The control word at address 0 is 2*PINS bits wide and reads back exactly as written. Bit 2n enables CPU drive of pin n, and bit 2n+1 enables the pullup of pin n.
- R2: A pin is high when the CPU drives it with a 1, or the peripheral drives it with a 1 (per_dir[n] and per_data[n]), or its pullup is on while neither the CPU nor the peripheral drives it. Otherwise the pin is low.
- R3: A read of address 1 (data) returns the resolved pin levels in bits PINS-1:0, with zeros above them, and not the value last written.
- R4: When a register write changes the resolved levels, notify[s] is high for exactly one cycle, on the cycle after the write's commit edge, for each slot s whose mask overlaps the changed pins.
- R5: A write that leaves every resolved level unchanged produces no notification.
- R6: Slot s's trigger mask is at address 4+s and reads back as written. A slot is not notified when the changed pins lie outside its mask.
- R7: A change of the resolved levels caused by per_dir or per_data notifies the masked slots. The pulse is high during the cycle after the first clock edge that sees the new inputs.
- R8: The I/O-interrupt control word at address 2 stores its low PINS bits and reads them back. Writing it changes neither the pin levels nor notify.
- R9: After reset, all registers read 0, the pins read 0 when the peripheral drives nothing, and notify is 0.
- R10: A data write uses only the low PINS bits of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 data, 2 interrupt control, 4+s slot mask |
| reg_wdata | input | 2*PINS | Write data |
| reg_rdata | output | 2*PINS | Read data for reg_addr, combinational |
| per_dir | input | PINS | Peripheral drive enable per pin |
| per_data | input | PINS | Peripheral drive value per pin |
| pin_level | output | PINS | Resolved pin levels |
| notify | output | SLOTS | One-cycle change pulse per slot |

## Verification
The resolution function is tested with CPU drive alone, with a pullup on an undriven pin, with a peripheral driving high, and with a peripheral driving low over a pullup. These cases separate the three OR terms and the "neither side drives" condition. Writes are chosen to cover three outcomes: one that changes pins in both mask halves, one that changes pins in only one half, and one that changes no level (data written to input pins, or an interrupt-control write). Together they distinguish per-slot masking from a global change flag. A data write that sets only the upper half of the bus shows that those bits are ignored, and a data readback after writing all ones shows that reads return resolved levels rather than the stored register.

// File: rtl/gpio_dual_port.sv
module gpio_dual_port #(
  parameter int PINS  = 16,
  parameter int SLOTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [2*PINS-1:0] reg_wdata,
  output logic [2*PINS-1:0] reg_rdata,
  input  logic [PINS-1:0]   per_dir,
  input  logic [PINS-1:0]   per_data,
  output logic [PINS-1:0]   pin_level,
  output logic [SLOTS-1:0]  notify
);
  localparam int CW = 2 * PINS;
  localparam logic [2:0] A_CTL  = 3'd0;
  localparam logic [2:0] A_DATA = 3'd1;
  localparam logic [2:0] A_IRQC = 3'd2;
  localparam int MASK_BASE = 4;

  logic [CW-1:0]   ctl_q;
  logic [PINS-1:0] dout_q, irqc_q, prev_q;
  logic [PINS-1:0] mask_q [SLOTS];
  logic [PINS-1:0] cpu_dir, pull_en, change;

  for (genvar n = 0; n < PINS; n++) begin : g_field
    assign cpu_dir[n] = ctl_q[2*n];
    assign pull_en[n] = ctl_q[2*n+1];
  end

  assign pin_level = (cpu_dir & dout_q) | (per_dir & per_data)
                   | (pull_en & ~(cpu_dir | per_dir));
  assign change = pin_level ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      dout_q <= '0;
      irqc_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= pin_level;
      if (reg_wr && reg_addr == A_CTL)  ctl_q  <= reg_wdata;
      if (reg_wr && reg_addr == A_DATA) dout_q <= reg_wdata[PINS-1:0];
      if (reg_wr && reg_addr == A_IRQC) irqc_q <= reg_wdata[PINS-1:0];
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[s] <= '0;
        notify[s] <= 1'b0;
      end else begin
        notify[s] <= |(mask_q[s] & change);
        if (reg_wr && reg_addr == 3'(MASK_BASE + s)) mask_q[s] <= reg_wdata[PINS-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTL:   reg_rdata = ctl_q;
      A_DATA:  reg_rdata[PINS-1:0] = pin_level;
      A_IRQC:  reg_rdata[PINS-1:0] = irqc_q;
      default: begin
        for (int s = 0; s < SLOTS; s++)
          if (reg_addr == 3'(MASK_BASE + s)) reg_rdata[PINS-1:0] = mask_q[s];
      end
    endcase
  end
endmodule

// File: rtl/gpio_dual_port_chk.sv
module gpio_dual_port_chk #(
  parameter int PINS  = 16,
  parameter int SLOTS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        reg_addr,
  input logic [2*PINS-1:0] reg_rdata,
  input logic [2*PINS-1:0] ctl_q,
  input logic [PINS-1:0]   dout_q,
  input logic [PINS-1:0]   per_dir,
  input logic [PINS-1:0]   per_data,
  input logic [PINS-1:0]   pin_level,
  input logic [SLOTS-1:0]  notify
);
  logic [PINS-1:0] d, p;
  logic [1:0] age;

  always_comb
    for (int n = 0; n < PINS; n++) begin
      d[n] = ctl_q[2*n];
      p[n] = ctl_q[2*n+1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  AST_CPU_DRIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((d & dout_q & ~pin_level) == '0)); // R2
  AST_PERIPH_DRIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((per_dir & per_data & ~pin_level) == '0)); // R2
  AST_IDLE_FOLLOWS_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
    ((~(d | per_dir) & (pin_level ^ p)) == '0)); // R2
  AST_DATA_READ_RESOLVED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd1) |-> (reg_rdata == {{PINS{1'b0}}, pin_level})); // R3
  AST_NOTIFY_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n || age < 2'd2)
    (notify != '0) |-> ($past(pin_level) != $past(pin_level, 2))); // R5
endmodule

bind gpio_dual_port gpio_dual_port_chk #(.PINS(PINS), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .ctl_q(ctl_q), .dout_q(dout_q), .per_dir(per_dir), .per_data(per_data),
  .pin_level(pin_level), .notify(notify)
);

// File: tb/gpio_dual_port_tb.sv
module gpio_dual_port_tb;
  localparam int PINS = 16, SLOTS = 2;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [15:0] per_dir = '0, per_data = '0, pin_level;
  logic [1:0] notify;
  int checks = 0, errors = 0;
  logic [31:0] m_ctl = 0;
  logic [15:0] m_dout = 0;

  gpio_dual_port #(.PINS(PINS), .SLOTS(SLOTS)) u_dut (.*);

  always #4 clk = ~clk;

  function automatic logic [15:0] model();
    logic [15:0] r;
    for (int n = 0; n < 16; n++) begin
      logic dd, pu;
      dd = m_ctl[2*n]; pu = m_ctl[2*n+1];
      r[n] = (dd & m_dout[n]) | (per_dir[n] & per_data[n]) | (pu & ~dd & ~per_dir[n]);
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] v);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
    if (a == 0) m_ctl = v;
    if (a == 1) m_dout = v[15:0];
  endtask

  task automatic rd_check(string req, logic [2:0] a, logic [31:0] exp);
    reg_addr = a; #1; check(req, reg_rdata, exp);
  endtask

  task automatic pulse_check(string req, logic [1:0] exp);
    @(negedge clk); check(req, {30'd0, notify}, {30'd0, exp});
    @(negedge clk); check({req, " pulse ends"}, {30'd0, notify}, 32'd0);
  endtask

  task automatic t_reset();
    rd_check("R9 ctl", 0, 0); rd_check("R9 data", 1, 0);
    rd_check("R9 irqc", 2, 0); rd_check("R9 mask0", 4, 0);
    check("R9 notify", {30'd0, notify}, 0); check("R9 pins", {16'd0, pin_level}, 0);
  endtask

  task automatic t_masks();
    wr(4, 32'h0000_00FF); wr(5, 32'h0000_FF00);
    rd_check("R6 mask0", 4, 32'h00FF); rd_check("R6 mask1", 5, 32'hFF00);
    pulse_check("R5 mask write", 2'b00);
  endtask

  task automatic t_cpu_drive();
    wr(0, 32'h0004_0001);
    rd_check("R1 ctl readback", 0, 32'h0004_0001);
    pulse_check("R5 dir only", 2'b00);
    wr(1, 32'h0000_0201);
    rd_check("R3 data", 1, {16'd0, model()});
    check("R2 cpu drive", {16'd0, pin_level}, 32'h0201);
    pulse_check("R4 both slots", 2'b11);
    wr(1, 32'h0000_FFFF);
    rd_check("R3 not last written", 1, 32'h0000_0201);
    pulse_check("R5 input pins only", 2'b00);
  endtask

  task automatic t_pullup();
    wr(0, 32'h0004_0081);
    check("R1 pullup bit 2n+1", {16'd0, pin_level}, {16'd0, model()});
    check("R2 pullup", {16'd0, pin_level}, 32'h0209);
    pulse_check("R6 low slot only", 2'b01);
  endtask

  task automatic t_periph();
    @(negedge clk); per_dir = 16'h1000; per_data = 16'h1000;
    #1 check("R2 periph high", {16'd0, pin_level}, {16'd0, model()});
    pulse_check("R7 periph high slot1", 2'b10);
    @(negedge clk); per_dir = 16'h1008; per_data = 16'h1000;
    #1 check("R2 periph low over pullup", {16'd0, pin_level}, 32'h1201);
    pulse_check("R7 periph low slot0", 2'b01);
  endtask

  task automatic t_irqc();
    wr(2, 32'h0000_ABCD);
    rd_check("R8 irqc readback", 2, 32'h0000_ABCD);
    check("R8 pins unchanged", {16'd0, pin_level}, 32'h1201);
    pulse_check("R8 no notify", 2'b00);
  endtask

  task automatic t_upper();
    wr(1, 32'hFFFF_0000);
    check("R10 upper ignored", {16'd0, pin_level}, {16'd0, model()});
    rd_check("R10 data", 1, 32'h0000_1000);
    pulse_check("R10 R4 both", 2'b11);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_cpu_drive();
    t_pullup();
    t_periph();
    t_irqc();
    t_upper();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule